// File: doc/BRIEF.md
# Set/Clear Control Register Bank

This block holds a small set of 32-bit control registers. Software does not overwrite them. Instead, each write carries its own set-or-clear instruction per byte. Within a byte lane, the most significant bit gives the level to apply. The seven bits below it name which register bits in that same lane take that level. Every other bit keeps its value.

Several agents can therefore change single control bits without a read-modify-write sequence and without racing one another. Each register has its own parameterised mask of implemented bits. One register bit may leave reset at a non-zero value. Bits listed in a pulse mask clear themselves one clock after being set.

The current values of all registers drive the surrounding logic in parallel. A read port returns one register through a registered data output.

Top module: `cmdreg_bank`

## Requirements
- R1: In a written byte lane b (0..3) whose data bit 8b+7 is 1, every register bit 8b+k (k = 0..6) whose data bit 8b+k is 1 becomes 1 at the clock edge of the write.
- R2: In a written byte lane b whose data bit 8b+7 is 0, every register bit 8b+k whose data bit 8b+k is 1 becomes 0 at that edge. Writing the implemented mask with all four level bits at zero clears the whole register.
- R3: Register bits whose select bit is 0 in an enabled lane keep their previous value.
- R4: A lane whose byte enable (wr_be[b]) is low is ignored, whatever its data.
- R5: Bits outside the register's implemented mask never change and read as 0. The level positions 31, 23, 15 and 7 never hold state and read as 0.
- R6: After reset every register is 0, except register RST_REG bit RST_BIT, which takes RST_VAL. The defaults are register 2, bit 16, value 1.
- R7: A bit in PULSE_MASK reads 1 for exactly one clock after a write sets it, and is 0 afterwards unless it is set again. By default these are register 1, bits 16 and 11:8.
- R8: rd_data shows the addressed register one clock after rd_en and holds its value while rd_en is low. An address of NUM_REGS or above reads 0.
- R9: A read and a write to the same register in the same cycle return the value from before the write.
- R10: A write to an address of NUM_REGS or above changes no register.
- R11: ctrl_q bits 32i+31..32i always carry the current value of register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Register index for write and read |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 4 | Byte-lane enables |
| wr_data | input | 32 | Per-lane level bit and bit selects |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| ctrl_q | output | NUM_REGS*32 | All register values, register i in bits 32i+31..32i |

## Verification
The bench builds the block with its default parameters: five registers, a three-bit address, the five default masks, pulse bits in register 1 and the non-zero reset bit in register 2. The three-bit address makes indices 5 to 7 reachable, so writes and reads beyond the bank are exercised. The mixed masks put unimplemented bits and level positions under both set and clear traffic. The pulse bits let the one-cycle lifetime be seen, including a set repeated on consecutive cycles.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  localparam int WORD_W  = 32;
  localparam int LANE_W  = 8;
  localparam int LANES   = WORD_W / LANE_W;
  localparam int SEL_W   = LANE_W - 1;

  typedef logic [WORD_W-1:0] word_t;

  // Positions that carry the level bit of each lane; they never store state.
  localparam word_t LEVEL_POS = 32'h8080_8080;
endpackage

// File: rtl/cmdreg_lane_dec.sv
module cmdreg_lane_dec
  import cmdreg_pkg::*;
(
  input  logic             hit,
  input  logic [LANES-1:0] be,
  input  word_t            data,
  output word_t            set_m,
  output word_t            clr_m
);
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic             lvl;
    logic [SEL_W-1:0] sel;
    logic             act;

    assign lvl = data[b*LANE_W + SEL_W];
    assign sel = data[b*LANE_W +: SEL_W];
    assign act = hit & be[b];

    assign set_m[b*LANE_W +: LANE_W] = (act &  lvl) ? {1'b0, sel} : '0;
    assign clr_m[b*LANE_W +: LANE_W] = (act & ~lvl) ? {1'b0, sel} : '0;
  end
endmodule

// File: rtl/cmdreg_word.sv
module cmdreg_word
  import cmdreg_pkg::*;
#(
  parameter word_t IMPL  = 32'h0000_0000,
  parameter word_t PULSE = 32'h0000_0000,
  parameter word_t RSTV  = 32'h0000_0000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hit,
  input  word_t set_m,
  input  word_t clr_m,
  output word_t q
);
  localparam word_t KEEP    = IMPL & ~LEVEL_POS;
  localparam word_t PULSE_L = PULSE & KEEP;
  localparam word_t RST_L   = RSTV & KEEP;

  word_t base;
  word_t q_nxt;
  logic  q_en;

  always_comb begin
    base  = q & ~PULSE_L;
    q_nxt = ((base & ~clr_m) | set_m) & KEEP;
    q_en  = hit | (|(q & PULSE_L));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RST_L;
    else if (q_en)   q <= q_nxt;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (q == ($past(q) & ~PULSE_L))) else $error("idle change"); // R3
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ((q & $past(set_m) & KEEP) == ($past(set_m) & KEEP))) else $error("set lost"); // R1
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ((q & $past(clr_m)) == '0)) else $error("clear lost"); // R2
  AST_PULSE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && (|(q & PULSE_L))) |=> ((q & PULSE_L) == '0)) else $error("pulse stuck"); // R7
endmodule

// File: rtl/cmdreg_rd_mux.sv
module cmdreg_rd_mux
  import cmdreg_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter int ADDR_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NUM_REGS*WORD_W-1:0] regs,
  output word_t                      rd_data
);
  word_t rd_nxt;

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (int'(addr) == i) rd_nxt = regs[i*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_nxt;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)) else $error("rd_data moved"); // R8
  AST_RD_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (int'(addr) >= NUM_REGS)) |=> (rd_data == '0)) else $error("oor read"); // R8
endmodule

// File: rtl/cmdreg_bank.sv
module cmdreg_bank
  import cmdreg_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter int ADDR_W   = 3,
  parameter logic [NUM_REGS-1:0][31:0] IMPL_MASK = {
    32'h0000_001B, 32'h2036_7E07, 32'h3F7F_3F7F, 32'h000F_0F7F, 32'h1F7F_7F1F},
  parameter logic [NUM_REGS-1:0][31:0] PULSE_MASK = {
    32'h0, 32'h0, 32'h0, 32'h0001_0F00, 32'h0},
  parameter int   RST_REG = 2,
  parameter int   RST_BIT = 16,
  parameter logic RST_VAL = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wr_en,
  input  logic [3:0]                 wr_be,
  input  logic [31:0]                wr_data,
  input  logic                       rd_en,
  output logic [31:0]                rd_data,
  output logic [NUM_REGS*32-1:0]     ctrl_q
);
  localparam int FLAT_W = NUM_REGS * WORD_W;

  // Reset synchroniser: asserts at once, releases on the clock.
  logic rst_meta;
  logic rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [FLAT_W-1:0] regs_flat;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam word_t RV = (i == RST_REG) ? (word_t'(RST_VAL) << RST_BIT) : '0;

    logic  hit;
    word_t set_m;
    word_t clr_m;
    word_t q;

    assign hit = wr_en & (int'(addr) == i);

    cmdreg_lane_dec u_dec (
      .hit   (hit),
      .be    (wr_be),
      .data  (wr_data),
      .set_m (set_m),
      .clr_m (clr_m)
    );

    cmdreg_word #(
      .IMPL  (IMPL_MASK[i]),
      .PULSE (PULSE_MASK[i]),
      .RSTV  (RV)
    ) u_word (
      .clk   (clk),
      .rst_n (rst_sync),
      .hit   (hit),
      .set_m (set_m),
      .clr_m (clr_m),
      .q     (q)
    );

    assign regs_flat[i*WORD_W +: WORD_W] = q;

    AST_LEVEL_POS_ZERO: assert property (@(posedge clk) disable iff (!rst_sync)
      hit |=> ((q & LEVEL_POS) == '0)) else $error("level bit stored"); // R5
  end

  assign ctrl_q = regs_flat;

  cmdreg_rd_mux #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_sync),
    .rd_en   (rd_en),
    .addr    (addr),
    .regs    (regs_flat),
    .rd_data (rd_data)
  );

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync)
    (wr_en && (int'(addr) >= NUM_REGS) && (|(ctrl_q & {NUM_REGS{32'h0001_0F00}})) == 1'b0)
    |=> $stable(ctrl_q)) else $error("oor write"); // R10
endmodule

// File: tb/cmdreg_bank_bench.sv
`timescale 1ns/1ps
module cmdreg_bank_bench;
  localparam int N = 5;
  localparam logic [31:0] MASK [N] = '{32'h1F7F_7F1F, 32'h000F_0F7F, 32'h3F7F_3F7F,
                                       32'h2036_7E07, 32'h0000_001B};
  localparam logic [31:0] PULS [N] = '{32'h0, 32'h0001_0F00, 32'h0, 32'h0, 32'h0};

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] addr;
  logic wr_en, rd_en;
  logic [3:0] wr_be;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [N*32-1:0] ctrl_q;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] model [N];

  always #2.5 clk = ~clk;

  cmdreg_bank u_cmdreg_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .ctrl_q(ctrl_q)
  );

  function automatic logic [31:0] apply(logic [31:0] cur, logic [31:0] m,
                                        logic [3:0] be, logic [31:0] d);
    logic [31:0] keep, r;
    keep = m & 32'h7F7F_7F7F;
    r = cur;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) begin
        for (int k = 0; k < 7; k++) begin
          if (d[8*b+k]) r[8*b+k] = d[8*b+7];
        end
      end
    end
    return r & keep;
  endfunction

  function automatic logic [N*32-1:0] flat();
    logic [N*32-1:0] f;
    for (int i = 0; i < N; i++) f[i*32 +: 32] = model[i];
    return f;
  endfunction

  task automatic check(string tag, logic [N*32-1:0] act, logic [N*32-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at a falling edge, update the model at the rising edge,
  // compare at the next falling edge.
  task automatic step(string tag, logic w, logic r, logic [2:0] a,
                      logic [3:0] be, logic [31:0] d);
    logic [31:0] rexp;
    wr_en = w; rd_en = r; addr = a; wr_be = be; wr_data = d;
    rexp = (int'(a) < N) ? model[a] : 32'h0;
    @(posedge clk);
    for (int i = 0; i < N; i++) model[i] = model[i] & ~PULS[i];
    if (w && int'(a) < N) model[a] = apply(model[a], MASK[a], be, d);
    @(negedge clk);
    check(tag, ctrl_q, flat());
    if (r) check(tag, {{(N-1)*32{1'b0}}, rd_data}, {{(N-1)*32{1'b0}}, rexp});
    wr_en = 0; rd_en = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wr_be = 0; wr_data = 0;
    for (int i = 0; i < N; i++) model[i] = 32'h0;
    model[2] = 32'h0001_0000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R6: reset values on the parallel output and through reads
    check("R6", ctrl_q, flat());
    for (int i = 0; i < N; i++) step("R6", 0, 1, 3'(i), 4'h0, 32'h0);

    // R1: set bits 1,3,4 of register 4 via lane 0
    step("R1", 1, 0, 3'd4, 4'h1, 32'h0000_009A);
    // R2: clear the same bits
    step("R2", 1, 0, 3'd4, 4'h1, 32'h0000_001A);
    // R1 R3: set across all lanes of register 0, then clear one bit only
    step("R1", 1, 0, 3'd0, 4'hF, 32'hFFFF_FFFF);
    step("R3", 1, 0, 3'd0, 4'h2, 32'h0000_0100);
    // R2: mask with level bits zero clears the whole register
    step("R2", 1, 1, 3'd0, 4'hF, 32'h1F7F_7F1F);
    step("R2", 0, 1, 3'd0, 4'h0, 32'h0);
    // R4: disabled lanes ignored
    step("R4", 1, 0, 3'd2, 4'h5, 32'hFFFF_FFFF);
    step("R4", 0, 1, 3'd2, 4'h0, 32'h0);
    // R5: unimplemented and level positions stay zero
    step("R5", 1, 1, 3'd3, 4'hF, 32'hFFFF_FFFF);
    step("R5", 0, 1, 3'd3, 4'h0, 32'h0);
    // R7: pulse bits last one clock; repeated set keeps them high
    step("R7", 1, 0, 3'd1, 4'h6, 32'h0081_8F00);
    step("R7", 0, 0, 3'd1, 4'h0, 32'h0);
    step("R7", 1, 0, 3'd1, 4'h2, 32'h0000_8100);
    step("R7", 1, 0, 3'd1, 4'h2, 32'h0000_8100);
    step("R7", 0, 0, 3'd1, 4'h0, 32'h0);
    // R9: simultaneous read and write return the old value
    step("R9", 1, 1, 3'd4, 4'h1, 32'h0000_009B);
    step("R9", 1, 1, 3'd4, 4'h1, 32'h0000_0003);
    // R10 R8: out-of-range write ignored, read returns zero
    step("R10", 1, 1, 3'd6, 4'hF, 32'hFFFF_FFFF);
    step("R8", 0, 1, 3'd7, 4'h0, 32'h0);
    step("R8", 0, 0, 3'd7, 4'h0, 32'h0);

    // R11: random traffic compared against the model
    for (int n = 0; n < 2000; n++) begin
      step("R11", 1'($urandom), 1'($urandom), 3'($urandom), 4'($urandom), $urandom);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule